// File: doc/BRIEF.md
# Host Port Slave Interface

This block lets an external host processor read and write a local memory over an asynchronous parallel bus that has no clock of its own. The host frames each access with a composite strobe built from a chip select and two data strobes. The host picks the target of the access with a two-bit control field, a read/write line and, in half-word mode, a half-word identifier. The block brings every host input into the local clock domain, detects the strobe edges there, and signals completion through an active-low ready line that the host must wait for.

Three targets sit behind the port: a control register, an address register, and a data window into the local memory. The data window can step the address after each word or leave it fixed. Reads fetch from memory through a request/acknowledge port. Writes go into a small first-in first-out buffer that drains to a separate valid/ready write port, so the host rarely waits on memory. A static mode input selects 32-bit word transfers or 16-bit transfers in which each word moves as two halves.

Top module: `hostport_slave`

## Requirements
- R1: After reset host_rdy_n is 1, mem_rd_req is 0 and mem_wr_valid is 0.
- R2: An access occurs only while host_cs_n is 0 and exactly one of host_ds1_n and host_ds2_n is 0. Either data strobe may frame the access. With both data strobes low, or with chip select high, ready stays 1 and no memory request is made.
- R3: host_ctl encodes the target: 00 is the control register and 01 is the address register. Both can be written and read back. In 16-bit mode host_hsel 0 addresses bits [15:0] and host_hsel 1 addresses bits [31:16], carried on host_wdata[15:0] and host_rdata[15:0] with host_rdata[31:16] reading 0.
- R4: A data read (host_ctl 1x, host_rnw 1) issues one memory read at the address register. host_rdy_n stays 1 until the acknowledged data is loaded, then goes 0 with the data on host_rdata.
- R5: Code 10 adds one to the word address after each completed word access. Code 11 leaves the address unchanged.
- R6: Data writes enter a WB_DEPTH-entry buffer and leave on the write port in issue order. Each entry carries the address and the data. While mem_wr_ready is 0 the presented entry is held stable.
- R7: A data write that starts while the buffer is full keeps host_rdy_n at 1 until an entry drains.
- R8: A write is committed, on the strobe rising edge, only if ready went low during that strobe. A strobe released before ready leaves registers, address and buffer unchanged.
- R9: A read fetch is issued only after the write buffer is empty, so a read returns data written before it.
- R10: In 16-bit mode a data read with host_hsel 0 fetches the word and returns its low half. With host_hsel 1 it returns the high half of that word without a new memory request. The address steps only after the high half.
- R11: In 16-bit mode a data write with host_hsel 0 is held internally. The following write with host_hsel 1 pushes one memory write, with the second half in bits [31:16] and the first half in [15:0].
- R12: A falling edge on host_as_n captures the select inputs, and the next access uses the captured values rather than the live inputs.
- R13: Once raised, mem_rd_req stays high until mem_rd_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| mode16 | input | 1 | 1 selects 16-bit half-word transfers; change only while idle |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ds1_n | input | 1 | Host data strobe one, active low |
| host_ds2_n | input | 1 | Host data strobe two, active low |
| host_as_n | input | 1 | Host address strobe, falling edge captures selects |
| host_ctl | input | 2 | Target select code |
| host_rnw | input | 1 | 1 read, 0 write |
| host_hsel | input | 1 | Half-word identifier (16-bit mode) |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Host read data, valid while host_rdy_n is 0 |
| host_rdy_n | output | 1 | Ready to host, active low |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Memory read word address |
| mem_rd_ack | input | 1 | Memory read acknowledge with data |
| mem_rd_data | input | DW | Memory read data |
| mem_wr_valid | output | 1 | Buffered write available |
| mem_wr_addr | output | AW | Buffered write word address |
| mem_wr_data | output | DW | Buffered write data |
| mem_wr_ready | input | 1 | Memory accepts the buffered write |

## Verification
The assertions assume a host that obeys the handshake. A read strobe is held low until ready falls, so an outstanding read request is never abandoned. The select lines and write data stay steady from before the strobe falls until after it rises, and the memory acknowledges only while a request is up. The stimulus tasks therefore wait on ready before releasing a strobe. They hold data and selects for several local cycles past the rising edge, and they leave idle gaps longer than the synchronizer delay. The one deliberately early release is a write, which never has a read request outstanding.

// File: rtl/hps_pkg.sv
package hps_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'b00,
    SEL_ADDR = 2'b01,
    SEL_DINC = 2'b10,
    SEL_DFIX = 2'b11
  } hps_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WBUF,
    ST_RDY
  } hps_st_e;

  typedef struct packed {
    logic [1:0] ctl;
    logic       rnw;
    logic       hsel;
  } hps_selv_t;

endpackage

// File: rtl/hps_sync.sv
module hps_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/hps_wbuf.sv
module hps_wbuf #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  output logic                     full,
  output logic                     empty,
  output logic [$clog2(DEPTH):0]   level,
  output logic                     out_valid,
  output logic [AW-1:0]            out_addr,
  output logic [DW-1:0]            out_data,
  input  logic                     out_ready
);

  localparam int PW = $clog2(DEPTH);
  localparam int EW = AW + DW;

  logic [EW-1:0] mem [DEPTH];
  logic [PW:0]   wp, rp;
  logic          pop;

  assign level     = wp - rp;
  assign empty     = (wp == rp);
  assign full      = (level == (PW+1)'(DEPTH));
  assign out_valid = !empty;
  assign pop       = out_valid && out_ready;
  assign {out_addr, out_data} = mem[rp[PW-1:0]];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wp[PW-1:0]] <= {push_addr, push_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop)           rp <= rp + 1'b1;
    end
  end

endmodule

// File: rtl/hostport_slave.sv
module hostport_slave
  import hps_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int WB_DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mode16,
  input  logic          host_cs_n,
  input  logic          host_ds1_n,
  input  logic          host_ds2_n,
  input  logic          host_as_n,
  input  logic [1:0]    host_ctl,
  input  logic          host_rnw,
  input  logic          host_hsel,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_rdy_n,
  output logic          mem_rd_req,
  output logic [AW-1:0] mem_rd_addr,
  input  logic          mem_rd_ack,
  input  logic [DW-1:0] mem_rd_data,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic          mem_wr_ready
);

  localparam int HW    = DW / 2;
  localparam int WB_PW = $clog2(WB_DEPTH);
  localparam int SYNW  = 8;

  // ---------------- input synchronizers ----------------
  logic      cs_s, ds1_s, ds2_s, as_s;
  hps_selv_t sel_s;
  logic [DW-1:0] data_s;

  hps_sync #(.W(SYNW), .RST_VAL(8'hF0)) u_sync_ctl (
    .clk (clk),
    .rst (rst),
    .d   ({host_cs_n, host_ds1_n, host_ds2_n, host_as_n, host_ctl, host_rnw, host_hsel}),
    .q   ({cs_s, ds1_s, ds2_s, as_s, sel_s})
  );

  hps_sync #(.W(DW)) u_sync_dat (
    .clk (clk),
    .rst (rst),
    .d   (host_wdata),
    .q   (data_s)
  );

  // ---------------- strobe decode and edges ----------------
  logic strb_n, strb_q, as_q;
  logic strb_fall, strb_rise, as_fall;

  assign strb_n = ~(ds1_s ^ ds2_s) | cs_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      strb_q <= 1'b1;
      as_q   <= 1'b1;
    end else begin
      strb_q <= strb_n;
      as_q   <= as_s;
    end
  end

  assign strb_fall = strb_q & ~strb_n;
  assign strb_rise = ~strb_q & strb_n;
  assign as_fall   = as_q & ~as_s;

  // ---------------- state ----------------
  hps_st_e       st;
  hps_selv_t     cur, sel_as, sel_eff;
  logic          as_pend;
  logic          rd_req_q, rdy_n_q;
  logic [DW-1:0] rdata_q, dbuf, ctrl_q;
  logic [AW-1:0] addr_q;
  logic [HW-1:0] wlow;

  logic                 wb_full, wb_empty;
  logic [WB_PW:0]       wb_level;
  logic                 commit, wr_commit, push, step;
  logic [DW-1:0]        push_data, addr_word, reg_word;

  assign sel_eff   = as_pend ? sel_as : sel_s;
  assign addr_word = DW'(addr_q);
  assign reg_word  = (sel_eff.ctl == SEL_ADDR) ? addr_word : ctrl_q;

  assign commit    = strb_rise && (st == ST_RDY);
  assign wr_commit = commit && !cur.rnw;
  assign push      = wr_commit && cur.ctl[1] && (!mode16 || cur.hsel);
  assign step      = commit && (cur.ctl == SEL_DINC) && (!mode16 || cur.hsel);
  assign push_data = mode16 ? {data_s[HW-1:0], wlow} : data_s;

  function automatic logic [DW-1:0] pick(input logic [DW-1:0] w, input logic m16, input logic hi);
    if (!m16) return w;
    return hi ? DW'(w[DW-1:HW]) : DW'(w[HW-1:0]);
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic m16, input logic hi);
    if (!m16) return d;
    return hi ? {d[HW-1:0], old[HW-1:0]} : {old[DW-1:HW], d[HW-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur      <= '0;
      sel_as   <= '0;
      as_pend  <= 1'b0;
      rd_req_q <= 1'b0;
      rdy_n_q  <= 1'b1;
      rdata_q  <= '0;
      dbuf     <= '0;
      ctrl_q   <= '0;
      addr_q   <= '0;
      wlow     <= '0;
    end else begin
      if (as_fall) begin
        sel_as  <= sel_s;
        as_pend <= 1'b1;
      end
      case (st)
        ST_IDLE: begin
          if (strb_fall) begin
            cur     <= sel_eff;
            as_pend <= 1'b0;
            if (!sel_eff.ctl[1]) begin
              rdata_q <= pick(reg_word, mode16, sel_eff.hsel);
              rdy_n_q <= 1'b0;
              st      <= ST_RDY;
            end else if (sel_eff.rnw) begin
              if (mode16 && sel_eff.hsel) begin
                rdata_q <= pick(dbuf, 1'b1, 1'b1);
                rdy_n_q <= 1'b0;
                st      <= ST_RDY;
              end else begin
                st <= ST_FETCH;
              end
            end else if (wb_full) begin
              st <= ST_WBUF;
            end else begin
              rdy_n_q <= 1'b0;
              st      <= ST_RDY;
            end
          end
        end
        ST_FETCH: begin
          if (strb_rise) begin
            rd_req_q <= 1'b0;
            st       <= ST_IDLE;
          end else if (rd_req_q && mem_rd_ack) begin
            rd_req_q <= 1'b0;
            dbuf     <= mem_rd_data;
            rdata_q  <= pick(mem_rd_data, mode16, 1'b0);
            rdy_n_q  <= 1'b0;
            st       <= ST_RDY;
          end else if (!rd_req_q && wb_empty) begin
            rd_req_q <= 1'b1;
          end
        end
        ST_WBUF: begin
          if (strb_rise) begin
            st <= ST_IDLE;
          end else if (!wb_full) begin
            rdy_n_q <= 1'b0;
            st      <= ST_RDY;
          end
        end
        ST_RDY: begin
          if (strb_rise) begin
            rdy_n_q <= 1'b1;
            st      <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase

      if (wr_commit && cur.ctl == SEL_CTRL)
        ctrl_q <= merge(ctrl_q, data_s, mode16, cur.hsel);
      if (wr_commit && cur.ctl == SEL_ADDR)
        addr_q <= AW'(merge(addr_word, data_s, mode16, cur.hsel));
      else if (step)
        addr_q <= addr_q + 1'b1;
      if (wr_commit && cur.ctl[1] && mode16 && !cur.hsel)
        wlow <= data_s[HW-1:0];
    end
  end

  // ---------------- write buffer ----------------
  hps_wbuf #(.AW(AW), .DW(DW), .DEPTH(WB_DEPTH)) u_wbuf (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_addr (addr_q),
    .push_data (push_data),
    .full      (wb_full),
    .empty     (wb_empty),
    .level     (wb_level),
    .out_valid (mem_wr_valid),
    .out_addr  (mem_wr_addr),
    .out_data  (mem_wr_data),
    .out_ready (mem_wr_ready)
  );

  assign host_rdata  = rdata_q;
  assign host_rdy_n  = rdy_n_q;
  assign mem_rd_req  = rd_req_q;
  assign mem_rd_addr = addr_q;

endmodule

// File: rtl/hps_chk.sv
module hps_chk #(
  parameter int DW    = 32,
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   host_rdy_n,
  input logic                   mem_rd_req,
  input logic                   mem_rd_ack,
  input logic                   mem_wr_valid,
  input logic                   mem_wr_ready,
  input logic [AW-1:0]          mem_wr_addr,
  input logic [DW-1:0]          mem_wr_data,
  input logic [$clog2(DEPTH):0] wb_level
);

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready |=> mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wb_level <= ($clog2(DEPTH)+1)'(DEPTH));

  // R13
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req && !mem_rd_ack |=> mem_rd_req);

  // R9
  rd_after_drain_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !mem_wr_valid);

  // R4
  busy_during_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> host_rdy_n);

  // R4
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req && mem_rd_ack |=> !host_rdy_n);

endmodule

bind hostport_slave hps_chk #(.DW(DW), .AW(AW), .DEPTH(WB_DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .host_rdy_n   (host_rdy_n),
  .mem_rd_req   (mem_rd_req),
  .mem_rd_ack   (mem_rd_ack),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .wb_level     (wb_level)
);

// File: tb/tb_hostport_slave.sv
module tb_hostport_slave;

  logic        clk = 1'b0;
  logic        rst;
  logic        mode16;
  logic        cs_n, ds1_n, ds2_n, as_n;
  logic [1:0]  ctl;
  logic        rnw, hsel;
  logic [31:0] wdata, rdata;
  logic        rdy_n;
  logic        rd_req, rd_ack;
  logic [15:0] rd_addr;
  logic [31:0] rd_data;
  logic        wr_valid, wr_ready;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  int checks = 0;
  int failures = 0;
  int ack_cnt = 0;
  int wr_cnt = 0;
  bit wr_stall = 0;

  logic [47:0] exp_wr_q[$];
  logic [31:0] rd_exp_q[$];
  logic [31:0] rd_obs_q[$];
  string       rd_tag_q[$];
  logic [31:0] mem_m [256];

  always #2 clk = ~clk;  // 250 MHz

  hostport_slave dut (
    .clk(clk), .rst(rst), .mode16(mode16),
    .host_cs_n(cs_n), .host_ds1_n(ds1_n), .host_ds2_n(ds2_n), .host_as_n(as_n),
    .host_ctl(ctl), .host_rnw(rnw), .host_hsel(hsel), .host_wdata(wdata),
    .host_rdata(rdata), .host_rdy_n(rdy_n),
    .mem_rd_req(rd_req), .mem_rd_addr(rd_addr), .mem_rd_ack(rd_ack), .mem_rd_data(rd_data),
    .mem_wr_valid(wr_valid), .mem_wr_addr(wr_addr), .mem_wr_data(wr_data), .mem_wr_ready(wr_ready)
  );

  function automatic logic [31:0] init_val(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  task automatic check(input bit c, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // memory model and write-side scoreboard monitor
  initial begin
    int rd_wait;
    logic [47:0] e;
    rd_wait = 0;
    for (int i = 0; i < 256; i++) mem_m[i] = init_val(i);
    wr_ready = 1'b0;
    rd_ack   = 1'b0;
    rd_data  = '0;
    forever begin
      @(negedge clk);
      #1;
      wr_ready = !wr_stall;
      if (wr_valid && wr_ready && !rst) begin
        wr_cnt++;
        mem_m[wr_addr[7:0]] = wr_data;
        if (exp_wr_q.size() == 0) begin
          check(1'b0, "R6 unexpected write", {wr_addr, wr_data[15:0]}, 32'h0);
        end else begin
          e = exp_wr_q.pop_front();
          check({wr_addr, wr_data} == e, "R6 write addr/data", wr_data, e[31:0]);
          check(wr_addr == e[47:32], "R6 write addr", 32'(wr_addr), 32'(e[47:32]));
        end
      end
      if (rd_ack) begin
        rd_ack = 1'b0;
      end else if (rd_req && !rst) begin
        rd_wait++;
        if (rd_wait == 2) begin
          rd_wait = 0;
          rd_ack  = 1'b1;
          rd_data = mem_m[rd_addr[7:0]];
          ack_cnt++;
        end
      end
    end
  end

  // read-side scoreboard monitor
  always @(negedge clk) begin
    logic [31:0] e, o;
    string t;
    while (rd_exp_q.size() > 0 && rd_obs_q.size() > 0) begin
      e = rd_exp_q.pop_front();
      o = rd_obs_q.pop_front();
      t = rd_tag_q.pop_front();
      check(o == e, t, o, e);
    end
  end

  // watchdog
  initial begin
    repeat (60000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  task automatic host_cycle(input logic [1:0] c, input logic r, input logic h, input logic [31:0] wd,
                            input bit use_ds2, input bit pre_as, input int max_wait,
                            output bit got, output logic [31:0] rd);
    got = 1'b0;
    rd  = '0;
    @(negedge clk);
    ctl = c; rnw = r; hsel = h; wdata = wd;
    if (pre_as) begin
      @(negedge clk); as_n = 1'b0;
      repeat (3) @(negedge clk); as_n = 1'b1;
      repeat (2) @(negedge clk); ctl = c ^ 2'b01;
    end
    @(negedge clk);
    cs_n = 1'b0;
    if (use_ds2) ds2_n = 1'b0; else ds1_n = 1'b0;
    for (int i = 0; i < max_wait && !got; i++) begin
      @(negedge clk);
      if (rdy_n == 1'b0) begin
        got = 1'b1;
        rd  = rdata;
      end
    end
    @(negedge clk);
    ds1_n = 1'b1; ds2_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic hwr(input logic [1:0] c, input logic h, input logic [31:0] wd, input string tag);
    bit g;
    logic [31:0] d;
    host_cycle(c, 1'b0, h, wd, 1'b0, 1'b0, 200, g, d);
    check(g, tag, 32'(g), 32'd1);
  endtask

  task automatic hrd(input logic [1:0] c, input logic h, input logic [31:0] exp, input string tag,
                     input bit use_ds2, input bit pre_as);
    bit g;
    logic [31:0] d;
    rd_exp_q.push_back(exp);
    rd_tag_q.push_back(tag);
    host_cycle(c, 1'b1, h, exp ^ 32'hFFFF_FFFF, use_ds2, pre_as, 200, g, d);
    rd_obs_q.push_back(g ? d : ~exp);
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 200 && (wr_valid || exp_wr_q.size() > 0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int a0, w0;
    bit g;
    logic [31:0] d;
    rst = 1'b1; mode16 = 1'b0;
    cs_n = 1'b1; ds1_n = 1'b1; ds2_n = 1'b1; as_n = 1'b1;
    ctl = 2'b00; rnw = 1'b1; hsel = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    check(rdy_n == 1'b1, "R1 rdy_n in reset", 32'(rdy_n), 32'd1);
    check(rd_req == 1'b0, "R1 rd_req in reset", 32'(rd_req), 32'd0);
    check(wr_valid == 1'b0, "R1 wr_valid in reset", 32'(wr_valid), 32'd0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(rdy_n == 1'b1, "R1 rdy_n after reset", 32'(rdy_n), 32'd1);

    // R3 control and address registers
    hwr(2'b00, 1'b0, 32'h1234_5678, "R3 ctrl write");
    hrd(2'b00, 1'b0, 32'h1234_5678, "R3 ctrl readback", 1'b0, 1'b0);
    hwr(2'b01, 1'b0, 32'h0000_0010, "R3 addr write");
    hrd(2'b01, 1'b0, 32'h0000_0010, "R3 addr readback", 1'b0, 1'b0);

    // R6 R5 buffered writes with auto-increment
    for (int i = 0; i < 3; i++) begin
      exp_wr_q.push_back({16'(16'h10 + i), 32'hD000_0000 + 32'(i)});
      hwr(2'b10, 1'b0, 32'hD000_0000 + 32'(i), "R6 data write");
    end
    wait_drain();
    hrd(2'b01, 1'b0, 32'h0000_0013, "R5 address stepped by three", 1'b0, 1'b0);

    // R4 R5 reads with auto-increment
    hwr(2'b01, 1'b0, 32'h0000_0010, "R3 addr write");
    a0 = ack_cnt;
    for (int i = 0; i < 3; i++)
      hrd(2'b10, 1'b0, 32'hD000_0000 + 32'(i), "R4 stepped read data", 1'b0, 1'b0);
    check(ack_cnt == a0 + 3, "R4 one fetch per word", 32'(ack_cnt - a0), 32'd3);

    // R9 read waits for buffered write; R5 fixed address
    wr_stall = 1'b1;
    hwr(2'b01, 1'b0, 32'h0000_0020, "R3 addr write");
    exp_wr_q.push_back({16'h0020, 32'hCAFE_0020});
    hwr(2'b11, 1'b0, 32'hCAFE_0020, "R9 write before read");
    fork
      begin
        repeat (20) @(negedge clk);
        wr_stall = 1'b0;
      end
    join_none
    hrd(2'b11, 1'b0, 32'hCAFE_0020, "R9 read returns buffered write", 1'b0, 1'b0);
    hrd(2'b11, 1'b0, 32'hCAFE_0020, "R5 fixed address reread", 1'b0, 1'b0);
    hrd(2'b01, 1'b0, 32'h0000_0020, "R5 fixed address unchanged", 1'b0, 1'b0);

    // R7 R8 full buffer and aborted write
    wr_stall = 1'b1;
    hwr(2'b01, 1'b0, 32'h0000_0030, "R3 addr write");
    for (int i = 0; i < 4; i++) begin
      exp_wr_q.push_back({16'(16'h30 + i), 32'hF000_0000 + 32'(i)});
      hwr(2'b10, 1'b0, 32'hF000_0000 + 32'(i), "R6 fill buffer");
    end
    w0 = wr_cnt;
    host_cycle(2'b10, 1'b0, 1'b0, 32'hBAD0_BAD0, 1'b0, 1'b0, 30, g, d);
    check(!g, "R7 ready held while buffer full", 32'(g), 32'd0);
    repeat (5) @(negedge clk);
    wr_stall = 1'b0;
    wait_drain();
    repeat (10) @(negedge clk);
    check(wr_cnt == w0 + 4, "R8 aborted write not committed", 32'(wr_cnt - w0), 32'd4);
    hrd(2'b01, 1'b0, 32'h0000_0034, "R8 address not stepped by abort", 1'b0, 1'b0);

    // R2 strobe decode
    a0 = ack_cnt;
    @(negedge clk); ctl = 2'b10; rnw = 1'b1;
    @(negedge clk); cs_n = 1'b0; ds1_n = 1'b0; ds2_n = 1'b0;
    repeat (12) @(negedge clk);
    check(rdy_n == 1'b1, "R2 both data strobes low ignored", 32'(rdy_n), 32'd1);
    check(ack_cnt == a0, "R2 no fetch with both strobes low", 32'(ack_cnt - a0), 32'd0);
    ds1_n = 1'b1; ds2_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
    ds1_n = 1'b0;
    repeat (12) @(negedge clk);
    check(rdy_n == 1'b1, "R2 chip select high ignored", 32'(rdy_n), 32'd1);
    check(ack_cnt == a0, "R2 no fetch with chip select high", 32'(ack_cnt - a0), 32'd0);
    ds1_n = 1'b1;
    repeat (4) @(negedge clk);
    hrd(2'b11, 1'b0, init_val(16'h34), "R2 access framed by second strobe", 1'b1, 1'b0);
    hrd(2'b01, 1'b0, 32'h0000_0034, "R2 address unchanged by ignored strobes", 1'b0, 1'b0);

    // R12 address strobe capture
    hrd(2'b01, 1'b0, 32'h0000_0034, "R12 captured select used", 1'b0, 1'b1);

    // 16-bit mode
    mode16 = 1'b1;
    repeat (4) @(negedge clk);
    hwr(2'b01, 1'b0, 32'h0000_0040, "R3 addr low half write");
    hwr(2'b01, 1'b1, 32'h0000_0000, "R3 addr high half write");
    hrd(2'b01, 1'b0, 32'h0000_0040, "R3 addr low half read", 1'b0, 1'b0);
    hrd(2'b00, 1'b1, 32'h0000_1234, "R3 ctrl high half read", 1'b0, 1'b0);
    hrd(2'b00, 1'b0, 32'h0000_5678, "R3 ctrl low half read", 1'b0, 1'b0);
    w0 = wr_cnt;
    hwr(2'b10, 1'b0, 32'h0000_BEEF, "R11 first half write");
    repeat (10) @(negedge clk);
    check(wr_cnt == w0, "R11 first half not pushed", 32'(wr_cnt - w0), 32'd0);
    exp_wr_q.push_back({16'h0040, 32'hDEAD_BEEF});
    hwr(2'b10, 1'b1, 32'h0000_DEAD, "R11 second half write");
    wait_drain();
    check(wr_cnt == w0 + 1, "R11 one write per word", 32'(wr_cnt - w0), 32'd1);
    hrd(2'b01, 1'b0, 32'h0000_0041, "R5 step after second half", 1'b0, 1'b0);
    hwr(2'b01, 1'b0, 32'h0000_0040, "R3 addr low half write");
    a0 = ack_cnt;
    hrd(2'b11, 1'b0, 32'h0000_BEEF, "R10 low half read", 1'b0, 1'b0);
    check(ack_cnt == a0 + 1, "R10 first half fetches", 32'(ack_cnt - a0), 32'd1);
    hrd(2'b11, 1'b1, 32'h0000_DEAD, "R10 high half read", 1'b0, 1'b0);
    check(ack_cnt == a0 + 1, "R10 second half no fetch", 32'(ack_cnt - a0), 32'd1);

    repeat (20) @(negedge clk);
    check(exp_wr_q.size() == 0, "R6 all expected writes seen", 32'(exp_wr_q.size()), 32'd0);
    check(rd_exp_q.size() == 0, "R4 all expected reads seen", 32'(rd_exp_q.size()), 32'd0);
    report();
    $finish;
  end

endmodule